// File: doc/BRIEF.md
# Serial Bootload Download Controller

This controller sits between a UART receiver/transmitter pair and a small program RAM and runs the loading handshake of a serial bootstrap. After reset it asks the transmitter to send one break character. It then waits for the first received character and uses it to pick one of three actions. A zero byte is what the looped-back break produces, and it requests an immediate jump to a fixed EEPROM entry address. The byte 0xFF keeps the fast default bit rate. The bytes 0xE0 and 0xC0 are what a 0xFF sent at the slow rate looks like when it is sampled at the fast rate, so they switch the UART to the slow rate.

After the first character, every received byte is written to RAM at an address that starts at zero and counts up. Each stored byte is also queued for echo on the transmit path, so the host can compare it. The host ends a download of any length from zero up to the RAM size by going quiet. When four character times pass at the active rate with no new character, the block pulses `done_o` and then holds the number of stored bytes. The character time is set by parameters for bit period and frame length.

Top module: `boot_dl_ctrl`

## Requirements
- R1: After reset the block raises `tx_valid_o` with `tx_break_o`=1 and `tx_data_o`=0x00 and holds them until `tx_ready_i` is seen. Received bytes that arrive before the break is accepted are ignored.
- R2: A first byte of 0x00 sets `jump_o`=1 and `jump_addr_o`=0xB600 and holds them. After that no RAM write and no `done_o` ever follows.
- R3: A first byte of 0xFF, or any value other than 0x00, 0xE0 or 0xC0, leaves `baud_slow_o`=0. The first byte is never written to RAM.
- R4: A first byte of 0xE0 or 0xC0 sets `baud_slow_o`=1 for the rest of the download.
- R5: The download ends when IDLE_CHARS*BITS_PER_CHAR*bit-period cycles pass with no receive strobe, using the slow bit period when `baud_slow_o`=1. The idle time is measured from the last byte, or from the first byte if no data follows. `done_o` is high in the cycle that follows the clock edge that completes that many idle cycles.
- R6: Each data byte raises `ram_we_o` in the cycle of its `rx_valid_i` strobe, with `ram_wdata_o` equal to the byte. `ram_addr_o` is 0 for the first data byte and increases by one for each later byte.
- R7: Each stored byte is then presented on `tx_data_o` with `tx_valid_o`=1 and `tx_break_o`=0. It is held until `tx_ready_i`, after which `tx_valid_o` falls.
- R8: `done_o` is high for exactly one cycle. From then on, `count_o` holds the number of stored bytes until reset; a download with no data gives 0.
- R9: A byte that arrives when RAM_BYTES bytes are already stored is not written and sets `overflow_o`=1, and `done_o` pulses in the next cycle.
- R10: After the download has ended, received bytes cause no RAM write and leave `count_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is on rx_data_i |
| rx_data_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transmitter accepts the presented character |
| tx_valid_o | output | 1 | A character is presented for transmit |
| tx_break_o | output | 1 | The presented character is a break |
| tx_data_o | output | 8 | Byte to transmit |
| baud_slow_o | output | 1 | 1 selects the slow bit rate for the UART |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |
| jump_o | output | 1 | Jump to the EEPROM entry is requested |
| jump_addr_o | output | 16 | Jump target address |
| done_o | output | 1 | One-cycle pulse when the download ends |
| count_o | output | CNT_W | Number of bytes stored |
| overflow_o | output | 1 | A byte arrived with RAM full |

## Verification
The bench sweeps the number of data bytes from zero to one past a small RAM size, at both rates. For each run it counts the exact cycle in which `done_o` rises. A timer that reloads late or early, or that ignores the slow rate, would move that cycle by one or more clock periods. A first byte that is wrongly written to RAM shows up as shifted addresses and data. The overflow case covers the byte that arrives at exactly full RAM, so an off-by-one in the full test would either write past the end or raise overflow one byte too early. Bytes sent before the break is accepted, after a jump, and after completion must leave the rate, the RAM port and the count untouched.

// File: rtl/boot_dl_pkg.sv
package boot_dl_pkg;
  typedef enum logic [2:0] {
    ST_BREAK, ST_CLASS, ST_LOAD, ST_FIN, ST_END, ST_JUMP
  } dl_state_t;

  typedef enum logic [1:0] {
    CLS_JUMP, CLS_FAST, CLS_SLOW
  } first_cls_t;
endpackage

// File: rtl/boot_first_byte.sv
module boot_first_byte
  import boot_dl_pkg::*;
(
  input  logic [7:0]  byte_i,
  output first_cls_t  cls_o
);
  always_comb begin
    unique case (byte_i)
      8'h00:        cls_o = CLS_JUMP;
      8'hE0, 8'hC0: cls_o = CLS_SLOW;
      default:      cls_o = CLS_FAST;
    endcase
  end
endmodule

// File: rtl/boot_idle_timer.sv
module boot_idle_timer #(
  parameter int unsigned BIT_CYC_FAST  = 256,
  parameter int unsigned BIT_CYC_SLOW  = 1667,
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned IDLE_CHARS    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  input  logic slow_i,
  output logic expire_o
);
  localparam int unsigned LimFast = IDLE_CHARS * BITS_PER_CHAR * BIT_CYC_FAST;
  localparam int unsigned LimSlow = IDLE_CHARS * BITS_PER_CHAR * BIT_CYC_SLOW;
  localparam int unsigned LimMax  = (LimSlow > LimFast) ? LimSlow : LimFast;
  localparam int unsigned TW      = $clog2(LimMax + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] last;

  assign last     = slow_i ? TW'(LimSlow - 1) : TW'(LimFast - 1);
  assign expire_o = run_i && !clear_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || clear_i)    cnt_q <= '0;
    else if (cnt_q != last)        cnt_q <= cnt_q + 1'b1;
  end

  // R5: a fresh strobe restarts the window, so no expiry on the next cycle
  assert_no_early_expire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && clear_i) |=> !expire_o);
endmodule

// File: rtl/boot_echo_tx.sv
module boot_echo_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brk_req_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output logic       tx_break_o,
  output logic [7:0] tx_data_o
);
  logic       vld_q;
  logic [7:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      dat_q <= data_i;
    end else if (tx_ready_i && !brk_req_i) begin
      vld_q <= 1'b0;
    end
  end

  assign tx_valid_o = brk_req_i || vld_q;
  assign tx_break_o = brk_req_i;
  assign tx_data_o  = brk_req_i ? 8'h00 : dat_q;

  // R7: a presented character stays until accepted
  assert_echo_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !load_i) |=> (tx_valid_o && $stable(tx_data_o)));
  // R1: a break always carries a zero byte
  assert_break_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_break_o |-> (tx_valid_o && tx_data_o == 8'h00));
endmodule

// File: rtl/boot_dl_ctrl.sv
module boot_dl_ctrl
  import boot_dl_pkg::*;
#(
  parameter int unsigned RAM_BYTES     = 512,
  parameter int unsigned BIT_CYC_FAST  = 256,
  parameter int unsigned BIT_CYC_SLOW  = 1667,
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned IDLE_CHARS    = 4,
  parameter logic [15:0] JUMP_ADDR     = 16'hB600,
  localparam int unsigned ADDR_W       = $clog2(RAM_BYTES),
  localparam int unsigned CNT_W        = $clog2(RAM_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic              tx_break_o,
  output logic [7:0]        tx_data_o,
  output logic              baud_slow_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              jump_o,
  output logic [15:0]       jump_addr_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              overflow_o
);
  dl_state_t  state_q, state_d;
  first_cls_t cls;
  logic [CNT_W-1:0] ptr_q;
  logic slow_q, ovf_q, full, store, expire, in_load;

  boot_first_byte u_cls (.byte_i(rx_data_i), .cls_o(cls));

  assign in_load = (state_q == ST_LOAD);
  assign full    = (ptr_q == CNT_W'(RAM_BYTES));
  assign store   = in_load && rx_valid_i && !full;

  boot_idle_timer #(
    .BIT_CYC_FAST(BIT_CYC_FAST), .BIT_CYC_SLOW(BIT_CYC_SLOW),
    .BITS_PER_CHAR(BITS_PER_CHAR), .IDLE_CHARS(IDLE_CHARS)
  ) u_idle (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_load), .clear_i(rx_valid_i),
    .slow_i(slow_q), .expire_o(expire)
  );

  boot_echo_tx u_echo (
    .clk_i(clk_i), .rst_ni(rst_ni), .brk_req_i(state_q == ST_BREAK),
    .load_i(store), .data_i(rx_data_i), .tx_ready_i(tx_ready_i),
    .tx_valid_o(tx_valid_o), .tx_break_o(tx_break_o), .tx_data_o(tx_data_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BREAK: if (tx_ready_i) state_d = ST_CLASS;
      ST_CLASS: if (rx_valid_i) state_d = (cls == CLS_JUMP) ? ST_JUMP : ST_LOAD;
      ST_LOAD: begin
        if (rx_valid_i && full) state_d = ST_FIN;
        else if (expire)        state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_END;
      ST_END:  state_d = ST_END;
      ST_JUMP: state_d = ST_JUMP;
      default: state_d = ST_BREAK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BREAK;
      ptr_q   <= '0;
      slow_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (store) ptr_q <= ptr_q + 1'b1;
      if (state_q == ST_CLASS && rx_valid_i) slow_q <= (cls == CLS_SLOW);
      if (in_load && rx_valid_i && full) ovf_q <= 1'b1;
    end
  end

  assign baud_slow_o = slow_q;
  assign ram_we_o    = store;
  assign ram_addr_o  = ptr_q[ADDR_W-1:0];
  assign ram_wdata_o = rx_data_i;
  assign jump_o      = (state_q == ST_JUMP);
  assign jump_addr_o = JUMP_ADDR;
  assign done_o      = (state_q == ST_FIN);
  assign count_o     = ptr_q;
  assign overflow_o  = ovf_q;

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_ptr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> (count_o == $past(count_o) + 1'b1));
  assert_jump_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> (!ram_we_o && !done_o));
  assert_ovf_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> done_o);
  assert_count_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_o) |-> ($stable(count_o) && !ram_we_o));
  assert_rate_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_load && $past(in_load)) |-> $stable(baud_slow_o));
endmodule

// File: tb/tb_boot_dl_ctrl.sv
module tb_boot_dl_ctrl;
  localparam int RAM = 8;
  localparam int BF = 2, BS = 5, BPC = 10, IC = 4;
  localparam int LF = IC * BPC * BF;
  localparam int LS = IC * BPC * BS;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic tx_valid, tx_break, baud_slow, ram_we, jump, done, ovf;
  logic [7:0] tx_data, ram_wdata;
  logic [2:0] ram_addr;
  logic [15:0] jump_addr;
  logic [3:0] count;
  int checks = 0, fails = 0, k = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  boot_dl_ctrl #(.RAM_BYTES(RAM), .BIT_CYC_FAST(BF), .BIT_CYC_SLOW(BS),
    .BITS_PER_CHAR(BPC), .IDLE_CHARS(IC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_ready_i(tx_ready), .tx_valid_o(tx_valid), .tx_break_o(tx_break),
    .tx_data_o(tx_data), .baud_slow_o(baud_slow), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .jump_o(jump),
    .jump_addr_o(jump_addr), .done_o(done), .count_o(count), .overflow_o(ovf));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; rx_valid = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic accept_break(input bit stray);
    chk(tx_valid && tx_break && tx_data == 8'h00, "R1 break", {tx_valid, tx_break, tx_data}, 10'h300);
    if (stray) begin
      rx_valid = 1; rx_data = 8'hFF;
      @(posedge clk); @(negedge clk);
      rx_valid = 0;
      chk(tx_valid && tx_break, "R1 break held", {tx_valid, tx_break}, 3);
    end
    tx_ready = 1;
    @(posedge clk); @(negedge clk);
    tx_ready = 0;
    chk(!tx_valid, "R1 break released", tx_valid, 0);
  endtask

  task automatic send_first(input logic [7:0] d);
    rx_valid = 1; rx_data = d;
    #1 chk(!ram_we, "R3 first byte not stored", ram_we, 0);
    @(posedge clk); @(negedge clk);
    rx_valid = 0; k = 0;
  endtask

  task automatic send_data(input logic [7:0] d, input int idx);
    rx_valid = 1; rx_data = d;
    #1 chk(ram_we && ram_addr == 3'(idx) && ram_wdata == d, "R6 write",
           {ram_we, ram_addr, ram_wdata}, {1'b1, 3'(idx), d});
    @(posedge clk); @(negedge clk);
    rx_valid = 0;
    chk(tx_valid && !tx_break && tx_data == d, "R7 echo", {tx_valid, tx_break, tx_data}, {2'b10, d});
    tx_ready = 1;
    @(posedge clk); @(negedge clk);
    tx_ready = 0;
    chk(!tx_valid, "R7 echo released", tx_valid, 0);
    k = 1;
  endtask

  task automatic wait_done(input int lim);
    while (!done && k < lim + 10) begin
      @(posedge clk); k++; @(negedge clk);
    end
    chk(done && k == lim, "R5 idle timeout", k, lim);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  task automatic after_end(input int n);
    rx_valid = 1; rx_data = 8'h5A;
    #1 chk(!ram_we, "R10 no write after end", ram_we, 0);
    @(posedge clk); @(negedge clk);
    rx_valid = 0;
    repeat (3) @(negedge clk);
    chk(count == 4'(n) && !done, "R10 count frozen", count, n);
  endtask

  task automatic run_dl(input logic [7:0] first, input int n, input bit slow);
    do_reset();
    accept_break(slow);
    send_first(first);
    chk(baud_slow == slow, slow ? "R4 slow rate" : "R3 fast rate", baud_slow, slow);
    chk(!jump, "R2 no jump", jump, 0);
    for (int i = 0; i < n; i++) send_data(8'(first ^ (i * 37 + n)), i);
    wait_done(slow ? LS : LF);
    chk(count == 4'(n) && !ovf, "R8 count", {ovf, count}, n);
    after_end(n);
  endtask

  initial begin
    for (int n = 0; n <= RAM; n++) begin
      run_dl(8'hFF, n, 0);
      run_dl((n % 2) ? 8'hC0 : 8'hE0, n, 1);
    end
    run_dl(8'h37, 3, 0);
    run_dl(8'h01, 0, 0);

    // R9 overflow
    do_reset();
    accept_break(0);
    send_first(8'hFF);
    for (int i = 0; i < RAM; i++) send_data(8'(i + 1), i);
    rx_valid = 1; rx_data = 8'hAA;
    #1 chk(!ram_we, "R9 full byte dropped", ram_we, 0);
    @(posedge clk); @(negedge clk);
    rx_valid = 0;
    chk(ovf && done, "R9 overflow and done", {ovf, done}, 3);
    chk(count == 4'(RAM), "R9 count", count, RAM);
    chk(!tx_valid, "R9 no echo", tx_valid, 0);

    // R2 jump
    do_reset();
    accept_break(0);
    send_first(8'h00);
    chk(jump && jump_addr == 16'hB600, "R2 jump", jump_addr, 16'hB600);
    rx_valid = 1; rx_data = 8'h42;
    #1 chk(!ram_we, "R2 no write", ram_we, 0);
    @(posedge clk); @(negedge clk);
    rx_valid = 0;
    for (int i = 0; i < LS + 5; i++) begin
      @(negedge clk);
      if (done) chk(0, "R2 no done", done, 0);
    end
    chk(jump && count == 0, "R2 jump held", {jump, count}, 5'h10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule